// File: doc/BRIEF.md
# Power-Good Output Sequencer

This block drives four active-low power-good outputs and an active-low gate-enable output for a hot-swap power controller. Each channel has its own active-low enable request. A supply-ok qualifier gates every output. A 4-bit control word sets the behaviour. Its low three bits select the operating mode. The mode decides whether the channels switch on in a fixed order or independently. It also decides whether an auxiliary input acts as an extra enable for channel 1, as a timed event monitor, or not at all.

In event-monitor modes a timer starts when a chosen anchor channel comes on. The auxiliary input must go high before the programmed number of cycles runs out. If it does not, the gate and every power-good output shut off. Channels after the anchor stay off until the auxiliary input has been seen high. Bit 3 of the control word selects how the shutdown recovers. Cleared, the shutdown is sticky until the reset input. Set, the shutdown clears when supply-ok drops.

Top module: `pgSequencer`

## Requirements
- R1: While the reset input is low, all four power-good outputs and the gate-enable output are high (off). They stay off until the qualifiers allow otherwise.
- R2: In cascade modes, channel k+1 (k = 1..3) comes on only while channel k is on. A disabled channel keeps every later channel off. Cascade is active in every mode except 3'b010.
- R3: In mode 3'b010, each channel follows only its own enable request and supply-ok. A disabled channel does not hold off later channels.
- R4: In modes 3'b010 and 3'b011, channel 1 is on only while the auxiliary input is high. In mode 3'b011, channels 2 to 4 also stay off while channel 1 is off.
- R5: In mode 3'b001, the auxiliary input has no effect on any output.
- R6: Modes 3'b000 and 3'b100 monitor on channel 4, 3'b101 on channel 3, 3'b110 on channel 2 and 3'b111 on channel 1. All of these modes cascade. Channels after the anchor stay off until the auxiliary input has been seen high while the anchor is on.
- R7: In a monitor mode, suppose the auxiliary input stays low for more than the delayCycles count after the anchor turns on. The gate-enable output and all power-good outputs then go high (off), and this holds even if delayCycles is 0.
- R8: If the auxiliary input goes high within the window, no shutdown occurs, and the held later channels then come on.
- R9: With control bit 3 = 0, a timeout shutdown persists through auxiliary input changes and supply-ok cycling. Only the reset input clears it.
- R10: With control bit 3 = 1, a timeout shutdown persists until supply-ok goes low. After supply-ok returns, sequencing restarts.
- R11: While supply-ok is low, all power-good outputs and the gate-enable output are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| ctrlWord | input | 4 | Bit 3: latch disable; bits 2:0: mode |
| enReqN | input | 4 | Active-low enable request per channel (bit 0 = channel 1) |
| supplyOk | input | 1 | Supply, gate and drain-sense qualifiers within limits |
| auxIn | input | 1 | Auxiliary enable / event-monitor input |
| delayCycles | input | DLY_W | Event-monitor window in clock cycles |
| pgN | output | 4 | Active-low power-good outputs (bit 0 = channel 1) |
| gateEnN | output | 1 | Active-low main gate enable |

## Verification
The bench checks a disabled middle channel under cascade, where a design that ignores the order would let channels 3 and 4 come on. It checks the anchor mapping with a held channel after channel 2. A wrong index would release that channel early or shut down on the wrong edge. It checks delayCycles of 0, where a timer that waits before testing the count would miss the timeout. The sticky and non-sticky recoveries are driven with both supply cycling and auxiliary changes; a latch that ignores bit 3 would recover in the wrong case or never recover.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
  typedef struct packed {
    logic       cascadeEn;
    logic       ch1Block;
    logic [3:0] holdMask;
    logic       killAll;
  } seqCmd_t;

  localparam logic [2:0] MODE_MON_LEGACY = 3'b000;
  localparam logic [2:0] MODE_PLAIN      = 3'b001;
  localparam logic [2:0] MODE_AUX_FREE   = 3'b010;
  localparam logic [2:0] MODE_AUX_CASC   = 3'b011;
endpackage

// File: rtl/pgseq_ctrl.sv
module pgseq_ctrl
  import pgseq_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       ctrlWord,
  input  logic             auxIn,
  input  logic             supplyOk,
  input  logic [DLY_W-1:0] delayCycles,
  input  logic [3:0]       pgOn,
  output seqCmd_t          cmd
);
  logic [2:0] mode;
  logic       latchEn;
  logic       monEn;
  logic [1:0] anchorIdx;
  logic       anchorOn;
  logic       anchorPrev;
  logic       armed;
  logic       monOk;
  logic       faultQ;
  logic [DLY_W-1:0] timer;

  assign mode      = ctrlWord[2:0];
  assign latchEn   = ~ctrlWord[3];
  assign monEn     = (mode == MODE_MON_LEGACY) || mode[2];
  assign anchorIdx = (mode == MODE_MON_LEGACY) ? 2'd3 : ~mode[1:0];
  assign anchorOn  = pgOn[anchorIdx];

  always_comb begin
    cmd.cascadeEn = (mode != MODE_AUX_FREE);
    cmd.ch1Block  = ((mode == MODE_AUX_FREE) || (mode == MODE_AUX_CASC)) && !auxIn;
    cmd.killAll   = faultQ;
    for (int i = 0; i < 4; i++) begin
      cmd.holdMask[i] = monEn && !monOk && (i > int'(anchorIdx));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      anchorPrev <= 1'b0;
      armed      <= 1'b0;
      monOk      <= 1'b0;
      faultQ     <= 1'b0;
      timer      <= '0;
    end else begin
      anchorPrev <= anchorOn;
      if (!monEn || !anchorOn) begin
        armed <= 1'b0;
        monOk <= 1'b0;
      end else if (!anchorPrev) begin
        timer <= delayCycles;
        armed <= !auxIn;
        monOk <= auxIn;
      end else if (armed) begin
        if (auxIn) begin
          armed <= 1'b0;
          monOk <= 1'b1;
        end else if (timer == '0) begin
          armed  <= 1'b0;
          faultQ <= 1'b1;
        end else begin
          timer <= timer - 1'b1;
        end
      end
      if (!latchEn && !supplyOk) faultQ <= 1'b0;
    end
  end

  assert_latch_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (latchEn && faultQ) |=> faultQ);

  assert_monok_no_fault_R8: assert property (@(posedge clk) disable iff (!rstN)
    monOk |-> !faultQ);
endmodule

// File: rtl/pgseq_datapath.sv
module pgseq_datapath
  import pgseq_pkg::*;
#(
  parameter int CH_N = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqCmd_t         cmd,
  input  logic [CH_N-1:0] enReqN,
  input  logic            supplyOk,
  output logic [CH_N-1:0] pgOn,
  output logic [CH_N-1:0] pgN,
  output logic            gateEnN
);
  logic [CH_N-1:0] pgOnQ;
  logic [CH_N-1:0] wantD;
  logic            gateOnQ;
  logic            baseOk;

  assign baseOk = supplyOk && !cmd.killAll;

  generate
    for (genvar i = 0; i < CH_N; i++) begin : gChan
      if (i == 0) begin : gFirst
        assign wantD[i] = baseOk && !enReqN[i] && !cmd.holdMask[i] && !cmd.ch1Block;
      end else begin : gLater
        assign wantD[i] = baseOk && !enReqN[i] && !cmd.holdMask[i] &&
                          (!cmd.cascadeEn || pgOnQ[i-1]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgOnQ   <= '0;
      gateOnQ <= 1'b0;
    end else begin
      pgOnQ   <= wantD;
      gateOnQ <= baseOk;
    end
  end

  assign pgOn    = pgOnQ;
  assign pgN     = ~(pgOnQ & {CH_N{~cmd.killAll}});
  assign gateEnN = ~(gateOnQ && !cmd.killAll);

  generate
    for (genvar i = 1; i < CH_N; i++) begin : gCascChk
      assert_cascade_order_R2: assert property (@(posedge clk) disable iff (!rstN)
        (cmd.cascadeEn && $rose(pgOnQ[i])) |-> $past(pgOnQ[i-1]));
    end
    for (genvar i = 0; i < CH_N; i++) begin : gHoldChk
      assert_hold_after_anchor_R6: assert property (@(posedge clk) disable iff (!rstN)
        cmd.holdMask[i] |=> !pgOnQ[i]);
    end
  endgenerate

  assert_kill_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.killAll |=> (pgOnQ == '0 && !gateOnQ));

  assert_supply_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (pgOnQ == '0 && !gateOnQ));
endmodule

// File: rtl/pgSequencer.sv
module pgSequencer
  import pgseq_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       ctrlWord,
  input  logic [3:0]       enReqN,
  input  logic             supplyOk,
  input  logic             auxIn,
  input  logic [DLY_W-1:0] delayCycles,
  output logic [3:0]       pgN,
  output logic             gateEnN
);
  seqCmd_t    cmd;
  logic [3:0] pgOn;

  pgseq_ctrl #(.DLY_W(DLY_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .auxIn(auxIn),
    .supplyOk(supplyOk), .delayCycles(delayCycles), .pgOn(pgOn), .cmd(cmd)
  );

  pgseq_datapath #(.CH_N(4)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .enReqN(enReqN), .supplyOk(supplyOk),
    .pgOn(pgOn), .pgN(pgN), .gateEnN(gateEnN)
  );
endmodule

// File: tb/tb_pgSequencer.sv
module tb_pgSequencer;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W = 16;
  localparam int NVEC = 11;
  // fields: ctrl[14:11] enReqN[10:7] aux[6] supply[5] expGateN[4] expPgN[3:0]
  localparam logic [14:0] VEC [NVEC] = '{
    {4'b1001, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0000},
    {4'b1001, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0000},
    {4'b1001, 4'b0010, 1'b0, 1'b1, 1'b0, 4'b1110},
    {4'b1010, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0001},
    {4'b1010, 4'b0010, 1'b1, 1'b1, 1'b0, 4'b0010},
    {4'b1011, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b1111},
    {4'b1011, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0000},
    {4'b1001, 4'b0000, 1'b1, 1'b0, 1'b1, 4'b1111},
    {4'b1111, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0000},
    {4'b1100, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0000},
    {4'b1111, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b1110}
  };
  localparam string VREQ [NVEC] = '{"R2", "R5", "R2", "R3", "R4", "R4", "R4",
                                    "R11", "R6", "R6", "R6"};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] ctrlWord = 4'b1001;
  logic [3:0] enReqN = 4'b0000;
  logic supplyOk = 1'b1;
  logic auxIn = 1'b0;
  logic [DLY_W-1:0] delayCycles = 16'd20;
  logic [3:0] pgN;
  logic gateEnN;
  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pgSequencer #(.DLY_W(DLY_W)) dut (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .enReqN(enReqN),
    .supplyOk(supplyOk), .auxIn(auxIn), .delayCycles(delayCycles),
    .pgN(pgN), .gateEnN(gateEnN)
  );

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [4:0] expV);
    nRun++;
    if ({gateEnN, pgN} !== expV) begin
      nFail++;
      $display("FAIL %s: {gateEnN,pgN} actual %b expected %b", req, {gateEnN, pgN}, expV);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
  endtask

  initial begin
    waitCyc(3);
    chk("R1", 5'b1_1111);
    for (int v = 0; v < NVEC; v++) begin
      ctrlWord = VEC[v][14:11];
      enReqN   = VEC[v][10:7];
      auxIn    = VEC[v][6];
      supplyOk = VEC[v][5];
      doReset();
      waitCyc(12);
      chk(VREQ[v], VEC[v][4:0]);
    end

    // R7 and R9: timeout with sticky latch
    ctrlWord = 4'b0111; enReqN = 4'b0000; auxIn = 1'b0; supplyOk = 1'b1;
    delayCycles = 16'd20;
    doReset();
    waitCyc(12);
    chk("R6", 5'b0_1110);
    waitCyc(30);
    chk("R7", 5'b1_1111);
    auxIn = 1'b1;
    waitCyc(10);
    chk("R9", 5'b1_1111);
    supplyOk = 1'b0; waitCyc(3); supplyOk = 1'b1;
    waitCyc(12);
    chk("R9", 5'b1_1111);
    doReset();
    waitCyc(12);
    chk("R9", 5'b0_0000);

    // R10: non-sticky recovery through supply cycling
    ctrlWord = 4'b1111; auxIn = 1'b0;
    doReset();
    waitCyc(45);
    chk("R7", 5'b1_1111);
    auxIn = 1'b1;
    waitCyc(10);
    chk("R10", 5'b1_1111);
    supplyOk = 1'b0; waitCyc(3);
    chk("R11", 5'b1_1111);
    supplyOk = 1'b1;
    waitCyc(12);
    chk("R10", 5'b0_0000);

    // R7: zero-length window
    ctrlWord = 4'b0100; auxIn = 1'b0; delayCycles = 16'd0;
    doReset();
    waitCyc(12);
    chk("R7", 5'b1_1111);

    // R8: aux arrives inside the window, anchor on channel 2
    ctrlWord = 4'b0110; auxIn = 1'b0; delayCycles = 16'd20;
    doReset();
    waitCyc(8);
    chk("R6", 5'b0_1100);
    auxIn = 1'b1;
    waitCyc(6);
    chk("R8", 5'b0_0000);
    waitCyc(40);
    chk("R8", 5'b0_0000);

    // R6/R7: legacy mode anchors on channel 4
    ctrlWord = 4'b0000; auxIn = 1'b0;
    doReset();
    waitCyc(10);
    chk("R6", 5'b0_0000);
    waitCyc(30);
    chk("R7", 5'b1_1111);

    // R1: reset forces everything off
    @(negedge clk); rstN = 1'b0;
    waitCyc(2);
    chk("R1", 5'b1_1111);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule